// File: doc/BRIEF.md
# Integrated Yellow Alarm Detector

This block turns a per-frame indication that the remote-alarm (yellow) pattern was seen into a filtered receive alarm state. Frame strobes are grouped into fixed windows of `FRAMES_PER_WINDOW` frames; 48 frames of 125 µs each give a 6 ms window. A window counts as a hit if the pattern was flagged on at least one of its frames. Each hit window moves an up/down integration counter one step up and each clean window moves it one step down. The alarm is raised when the counter reaches `DECLARE_LEVEL` (80) and dropped only when the counter falls back to zero, so short bursts and short gaps do not make the state toggle.

Every change of the alarm state sets a sticky change flag. That flag drives an interrupt line through two enables: a source-level enable and a block-level enable. Software sees the alarm bit and the change flag in one status word on a small register port. The change flag is cleared either by reading the status word, when clear-on-read is selected, or by writing a 1 to its bit position.

Top module: `yel_alarm_integrator`

## Requirements
- R1: Each window spans `FRAMES_PER_WINDOW` cycles with `frameTick` high. A window is valid when `patternSeen` was high together with `frameTick` on any frame of that window. The window timer starts again after the last frame of each window.
- R2: The integration counter rises by one at the end of each valid window and stays at `DECLARE_LEVEL`. It falls by one at the end of each invalid window and stays at 0.
- R3: `alarmState` becomes 1 on the clock edge at which the counter reaches `DECLARE_LEVEL`. It becomes 0 on the edge at which the counter reaches 0. At any other counter value it keeps its previous value.
- R4: A read at address 0 returns bit 0 = alarm state, bit 1 = change flag, and all other bits 0. `busRdata` is combinational from `busAddr`. Any other address reads as all zeros.
- R5: `stateChange` is set on every clock edge at which `alarmState` changes, both on declaration and on removal.
- R6: `irqOut` is 1 exactly when `stateChange`, `srcIntEn` and `blkIntEn` are all 1.
- R7: With `clearOnRead` = 1, a read of address 0 clears `stateChange` on that edge. With `clearOnRead` = 0, a read leaves it unchanged.
- R8: A write to address 0 with data bit 1 = 1 clears `stateChange`. A write with that bit 0, or a write to another address, leaves `stateChange` unchanged. No write changes `alarmState`.
- R9: If a clear (by read or by write) and an alarm state change fall on the same edge, `stateChange` ends up 1.
- R10: While `rstN` is low, the counter, the window timer, `alarmState` and `stateChange` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle strobe per received frame |
| patternSeen | input | 1 | Yellow pattern seen in this frame; sampled with `frameTick` |
| srcIntEn | input | 1 | Source-level enable of the state-change interrupt |
| blkIntEn | input | 1 | Block-level enable of the state-change interrupt |
| clearOnRead | input | 1 | 1: a status read clears the change flag; 0: only a write clears it |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address; the status word is at 0 |
| busWdata | input | DATA_W | Write data; bit 1 = 1 clears the change flag |
| busRdata | output | DATA_W | Read data |
| alarmState | output | 1 | Declared receive yellow alarm |
| stateChange | output | 1 | Sticky alarm state-change flag |
| irqOut | output | 1 | State-change interrupt |

## Verification
Most internal faults in this block are hidden at first. A wrong window timer or a wrong counter step only shows up when `alarmState` rises or falls on the wrong edge. That can be up to 80 windows (3840 frames) after the fault, so the bench runs the alarm fully up to the declare level and fully back down, and it compares every edge against its own model. A wrong saturation point shows up as a late clear after a single clean window that follows saturation. A fault in the flag or interrupt path shows up at the next edge as a wrong `stateChange`, `irqOut` or status word.

// File: rtl/yel_pkg.sv
package yel_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic windowEnd;    // last frame of the current window is being taken
    logic windowValid;  // pattern was seen somewhere in the window
    logic flagClear;    // a software clear of the change flag is requested
  } yel_strb_t;

  localparam int ALARM_BIT  = 0;
  localparam int CHANGE_BIT = 1;
endpackage

// File: rtl/yel_ctrl.sv
module yel_ctrl
  import yel_pkg::*;
#(
  parameter int FRAMES_PER_WINDOW = 48,
  parameter int ADDR_W            = 2,
  parameter int DATA_W            = 8,
  parameter int STATUS_ADDR       = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              patternSeen,
  input  logic              clearOnRead,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output yel_strb_t         strb
);
  localparam int FW = (FRAMES_PER_WINDOW > 1) ? $clog2(FRAMES_PER_WINDOW) : 1;
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES_PER_WINDOW - 1);

  logic [FW-1:0] frameCnt;
  logic          seenFlag;
  logic          lastFrame;
  logic          statusHit;
  logic          unusedData;

  assign lastFrame  = frameTick && (frameCnt == LAST_FRAME);
  assign statusHit  = (busAddr == ADDR_W'(STATUS_ADDR));
  assign unusedData = ^busWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      seenFlag <= 1'b0;
    end else if (frameTick) begin
      if (lastFrame) begin
        frameCnt <= '0;
        seenFlag <= 1'b0;
      end else begin
        frameCnt <= frameCnt + 1'b1;
        seenFlag <= seenFlag | patternSeen;
      end
    end
  end

  always_comb begin
    strb.windowEnd   = lastFrame;
    strb.windowValid = seenFlag | patternSeen;
    strb.flagClear   = statusHit &&
                       ((busRd && clearOnRead) || (busWr && busWdata[CHANGE_BIT]));
  end

  // R1: window timer never passes the last frame
  a_r1_timer_range: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= LAST_FRAME);

  // R1: without a frame strobe the timer holds
  a_r1_timer_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(frameCnt));
endmodule

// File: rtl/yel_dp.sv
module yel_dp
  import yel_pkg::*;
#(
  parameter int DECLARE_LEVEL = 80,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 8,
  parameter int STATUS_ADDR   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  yel_strb_t         strb,
  input  logic              srcIntEn,
  input  logic              blkIntEn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmState,
  output logic              stateChange,
  output logic              irqOut
);
  localparam int CW = $clog2(DECLARE_LEVEL + 1);
  localparam logic [CW-1:0] TOP_LEVEL = CW'(DECLARE_LEVEL);

  logic [CW-1:0] integCnt;
  logic [CW-1:0] integNext;
  logic          alarmNext;
  logic          changeNow;
  logic          changeFlag;

  // Up/down integration with saturation
  always_comb begin
    integNext = integCnt;
    if (strb.windowEnd) begin
      if (strb.windowValid && (integCnt != TOP_LEVEL))
        integNext = integCnt + 1'b1;
      else if (!strb.windowValid && (integCnt != '0))
        integNext = integCnt - 1'b1;
    end
  end

  // Hysteresis: declare at the top, remove at zero, hold between
  always_comb begin
    alarmNext = alarmState;
    if (integNext == TOP_LEVEL)
      alarmNext = 1'b1;
    else if (integNext == '0)
      alarmNext = 1'b0;
  end

  assign changeNow = (alarmNext != alarmState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integCnt   <= '0;
      alarmState <= 1'b0;
      changeFlag <= 1'b0;
    end else begin
      integCnt   <= integNext;
      alarmState <= alarmNext;
      if (changeNow)
        changeFlag <= 1'b1;
      else if (strb.flagClear)
        changeFlag <= 1'b0;
    end
  end

  assign stateChange = changeFlag;
  assign irqOut      = changeFlag & srcIntEn & blkIntEn;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(STATUS_ADDR)) begin
      busRdata[ALARM_BIT]  = alarmState;
      busRdata[CHANGE_BIT] = changeFlag;
    end
  end

  // R2: counter stays inside its limits
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    integCnt <= TOP_LEVEL);

  // R2: counter moves only at a window end
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.windowEnd |=> $stable(integCnt));

  // R3: alarm rises only at the top level
  a_r3_rise_top: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmState) |-> (integCnt == TOP_LEVEL));

  // R3: alarm falls only at zero
  a_r3_fall_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmState) |-> (integCnt == '0));

  // R5, R9: any state change leaves the flag set
  a_r5_flag_on_change: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(alarmState) || $fell(alarmState)) |-> stateChange);

  // R7, R8: a clear with no concurrent change drops the flag
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagClear && !changeNow) |=> !stateChange);
endmodule

// File: rtl/yel_alarm_integrator.sv
module yel_alarm_integrator
  import yel_pkg::*;
#(
  parameter int FRAMES_PER_WINDOW = 48,
  parameter int DECLARE_LEVEL     = 80,
  parameter int ADDR_W            = 2,
  parameter int DATA_W            = 8,
  parameter int STATUS_ADDR       = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              patternSeen,
  input  logic              srcIntEn,
  input  logic              blkIntEn,
  input  logic              clearOnRead,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmState,
  output logic              stateChange,
  output logic              irqOut
);
  yel_strb_t strb;

  yel_ctrl #(
    .FRAMES_PER_WINDOW(FRAMES_PER_WINDOW),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .frameTick(frameTick),
    .patternSeen(patternSeen),
    .clearOnRead(clearOnRead),
    .busRd(busRd),
    .busWr(busWr),
    .busAddr(busAddr),
    .busWdata(busWdata),
    .strb(strb)
  );

  yel_dp #(
    .DECLARE_LEVEL(DECLARE_LEVEL),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .srcIntEn(srcIntEn),
    .blkIntEn(blkIntEn),
    .busAddr(busAddr),
    .busRdata(busRdata),
    .alarmState(alarmState),
    .stateChange(stateChange),
    .irqOut(irqOut)
  );
endmodule

// File: tb/sim_yel_alarm_integrator.sv
module sim_yel_alarm_integrator;
  localparam int FR  = 48;
  localparam int DEC = 80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameTick = 1'b0, patternSeen = 1'b0;
  logic       srcIntEn = 1'b0, blkIntEn = 1'b0, clearOnRead = 1'b0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       alarmState, stateChange, irqOut;

  int checks = 0;
  int fails  = 0;
  bit collideMode = 0;
  int collideHits = 0;

  // reference model state
  int mFrame = 0;
  bit mSeen = 0;
  int mCnt = 0;
  bit mAlarm = 0;
  bit mFlag = 0;

  always #2 clk = ~clk;

  yel_alarm_integrator u0 (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .patternSeen(patternSeen),
    .srcIntEn(srcIntEn), .blkIntEn(blkIntEn), .clearOnRead(clearOnRead),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .alarmState(alarmState), .stateChange(stateChange),
    .irqOut(irqOut)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // next counter and alarm for one edge (R1, R2, R3)
  function automatic void calcNext(bit ft, bit ps, output int nCnt, output bit nAlarm);
    nCnt = mCnt;
    if (ft && mFrame == FR - 1) begin
      if (mSeen || ps) nCnt = (mCnt < DEC) ? mCnt + 1 : DEC;
      else             nCnt = (mCnt > 0) ? mCnt - 1 : 0;
    end
    nAlarm = mAlarm;
    if (nCnt == DEC) nAlarm = 1;
    else if (nCnt == 0) nAlarm = 0;
  endfunction

  task automatic step(bit ft, bit ps, bit rd, bit wr, bit [7:0] wd, bit [1:0] ad,
                      bit cor, bit se, bit be, string flagTag);
    int  nCnt;
    bit  nAlarm, chg, clr;
    calcNext(ft, ps, nCnt, nAlarm);
    chg = (nAlarm != mAlarm);
    if (collideMode && chg) begin
      rd = 1; ad = 0; cor = 1; collideHits++;
      flagTag = "R9";
    end
    @(negedge clk);
    frameTick = ft; patternSeen = ps; busRd = rd; busWr = wr; busWdata = wd;
    busAddr = ad; clearOnRead = cor; srcIntEn = se; blkIntEn = be;
    #1;
    check("R1 R2 R3", "alarmState", int'(alarmState), int'(mAlarm));
    check(flagTag, "stateChange", int'(stateChange), int'(mFlag));
    check("R6", "irqOut", int'(irqOut), int'(mFlag & se & be));
    check("R4", "busRdata", int'(busRdata), (ad == 0) ? int'({mFlag, mAlarm}) : 0);
    @(posedge clk);
    clr = (ad == 0) && ((rd && cor) || (wr && wd[1]));
    if (ft) begin
      if (mFrame == FR - 1) begin mFrame = 0; mSeen = 0; end
      else begin mFrame++; mSeen = mSeen | ps; end
    end
    mCnt = nCnt;
    mAlarm = nAlarm;
    if (chg) mFlag = 1;
    else if (clr) mFlag = 0;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 8'h00, 2'd0, 0, 1, 1, tag);
  endtask

  // random traffic that never clears the flag
  task automatic softStep(int psPct, string tag);
    bit ft = ($urandom_range(3) != 0);
    bit ps = ($urandom_range(99) < psPct);
    step(ft, ps, ($urandom_range(7) == 0), ($urandom_range(7) == 0),
         8'($urandom) & 8'hFD, 2'($urandom), 0, 1'($urandom), 1'($urandom), "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int guard;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", "alarmState", int'(alarmState), 0);
    check("R10", "stateChange", int'(stateChange), 0);
    check("R10", "irqOut", int'(irqOut), 0);
    @(negedge clk); rstN = 1;

    // R1: pattern seen only on the last frame of every window still counts
    for (int w = 0; w < 3; w++)
      for (int f = 0; f < FR; f++)
        step(1, (f == FR - 1), 0, 0, 8'h00, 2'd0, 0, 1, 1, "R1");

    // declare the alarm under random traffic (R3, R5)
    guard = 0;
    while (!mAlarm && guard < 40000) begin softStep(8, "R5"); guard++; end
    check("R3", "declared", int'(mAlarm), 1);
    for (int i = 0; i < FR * 6; i++) step(1, 1, 0, 0, 8'h00, 2'd0, 0, 1, 1, "R2");

    // R2: saturated, one clean window then one valid window keeps the alarm
    for (int f = 0; f < FR; f++) step(1, 0, 0, 0, 8'h00, 2'd0, 0, 1, 0, "R2");
    for (int f = 0; f < FR; f++) step(1, 1, 0, 0, 8'h00, 2'd0, 0, 0, 1, "R2");

    // R7, R8, R4: clear paths
    step(0, 0, 1, 0, 8'h00, 2'd0, 0, 1, 1, "R7");  // read, clear-on-read off
    step(0, 0, 0, 1, 8'hFD, 2'd0, 0, 1, 1, "R8");  // write with bit 1 low
    step(0, 0, 0, 1, 8'h02, 2'd1, 0, 1, 1, "R8");  // write to other address
    step(0, 0, 1, 0, 8'h00, 2'd1, 1, 1, 1, "R4");  // read other address
    idle("R8");
    step(0, 0, 1, 0, 8'h00, 2'd0, 1, 1, 1, "R7");  // read with clear-on-read
    idle("R7");
    step(0, 0, 0, 1, 8'hFF, 2'd0, 0, 1, 1, "R8");  // write 1s: alarm stays
    idle("R8");

    // R9: remove the alarm with a read-clear on the changing edge
    collideMode = 1;
    guard = 0;
    while (mAlarm && guard < 20000) begin
      step(1, 0, 0, 0, 8'h00, 2'd0, 0, 1, 1, "R9");
      guard++;
    end
    collideMode = 0;
    check("R9", "collision happened", collideHits, 1);
    idle("R9");
    idle("R9");

    // random walk with every kind of clear mixed in
    for (int i = 0; i < 30000; i++) begin
      bit ft = ($urandom_range(3) != 0);
      int pct = (i < 15000) ? 6 : 1;
      step(ft, ($urandom_range(99) < pct), ($urandom_range(15) == 0),
           ($urandom_range(15) == 0), 8'($urandom), 2'($urandom_range(3) == 0 ? 1 : 0),
           1'($urandom), 1'($urandom), 1'($urandom), "R5 R7 R8 R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule